// File: doc/BRIEF.md
# Serial EEPROM-style I2C target

This block is an I2C target that behaves like a small serial EEPROM. It answers one 7-bit bus address, set by a parameter. It holds its contents in an internal byte array. A controller first writes two address bytes, high byte first, to load the target's internal pointer. It can then follow them with data bytes to store at that pointer. It can instead send a repeated START and a read header, and the target then streams bytes out from the loaded location.

Written bytes are gathered in a page buffer and reach the array only when the STOP arrives. The target then reports a programming period of a set number of system clocks. During that period it ignores its own address.

The SCL and SDA inputs are expected to be already synchronized to the system clock. The target pulls SDA low through a single drive-low output, and a status output shows the programming period.

Top module: `seeprom_tgt`

## Requirements
- R1: After reset the target releases SDA, reports not busy, and every array byte reads as 0x00.
- R2: The target acknowledges a header whose upper seven bits equal DEV_ADDR (bit 0 is the direction, 0 = write, 1 = read). For any other address it leaves the acknowledge bit high and releases SDA.
- R3: After a write header, the target takes two address bytes, high then low, and keeps the low log2(MEM_BYTES) bits as the pointer. The following data bytes are stored from that pointer once STOP arrives.
- R4: During a write, the pointer's offset within its PAGE_BYTES page wraps to the page start. The page number never changes, so bytes past the page end overwrite the start of the same page.
- R5: A STOP that ends a write carrying at least one data byte raises busy for exactly BUSY_CYCLES system clocks. A write that carries only the address bytes leaves busy low.
- R6: While busy is high, a header carrying the target's own address gets no acknowledge.
- R7: A repeated START after the two address bytes, with no STOP in between, keeps the loaded pointer. A read that follows returns data starting at that address.
- R8: On reads the pointer advances by one after each byte sent. It wraps from the last array byte to byte 0.
- R9: After the controller answers a read byte with NACK, the target stops driving SDA and sends nothing more.
- R10: A read header with no address phase before it continues from where the previous transfer left the pointer.
- R11: The target changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronized bus clock level |
| sda_i | input | 1 | Synchronized bus data level |
| sda_drive_low_o | output | 1 | 1 pulls SDA low, 0 releases it |
| busy_o | output | 1 | High during the programming period after a write |

## Verification
The hardest case to reach is a header that arrives inside the programming window. The window only opens after a complete write, and it closes by itself after a fixed count. The bench therefore issues a full addressed header right after the STOP of a data write, and it sets BUSY_CYCLES long enough that the whole header fits inside the window. The page wrap and the array wrap also need exact address placement. The bench writes across the end of a page and across the last byte of the array, then reads back through a repeated START from addresses on both sides of each boundary.

// File: rtl/seeprom_pkg.sv
package seeprom_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_TXACK
    } fsm_e;

    typedef enum logic [1:0] {
        K_DEV,
        K_AHI,
        K_ALO,
        K_DATA
    } kind_e;

endpackage

// File: rtl/seeprom_bus_cond.sv
module seeprom_bus_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic start_o,
    output logic stop_o,
    output logic rise_o,
    output logic fall_o
);
    typedef struct packed {
        logic scl;
        logic sda;
    } lvl_t;

    lvl_t lvl_d, lvl_q;

    always_comb begin
        lvl_d.scl = scl_i;
        lvl_d.sda = sda_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= '{scl: 1'b1, sda: 1'b1};
        else        lvl_q <= lvl_d;
    end

    assign start_o = lvl_q.scl & scl_i & lvl_q.sda & ~sda_i;
    assign stop_o  = lvl_q.scl & scl_i & ~lvl_q.sda & sda_i;
    assign rise_o  = ~lvl_q.scl & scl_i;
    assign fall_o  = lvl_q.scl & ~scl_i;

endmodule

// File: rtl/seeprom_busy_timer.sv
module seeprom_busy_timer #(
    parameter int CYCLES = 300
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start_i)            cnt_d = CW'(CYCLES);
        else if (cnt_q != '0)   cnt_d = cnt_q - CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy_o = (cnt_q != '0);

    // R5: a commit request opens the busy window on the next clock
    p_busy_opens_r5: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> busy_o);

endmodule

// File: rtl/seeprom_tgt.sv
module seeprom_tgt
    import seeprom_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h50,
    parameter int         MEM_BYTES   = 256,
    parameter int         PAGE_BYTES  = 32,
    parameter int         BUSY_CYCLES = 300
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_drive_low_o,
    output logic busy_o
);
    localparam int AW = $clog2(MEM_BYTES);
    localparam int OW = $clog2(PAGE_BYTES);

    typedef struct packed {
        fsm_e                        st;
        kind_e                       kind;
        logic [3:0]                  cnt;
        logic [7:0]                  sh;
        logic                        drv;
        logic                        rd;
        logic [AW-1:0]               ptr;
        logic [7:0]                  ahi;
        logic [PAGE_BYTES-1:0]       vld;
        logic [PAGE_BYTES-1:0][7:0]  pbuf;
    } ctl_t;

    ctl_t        d, q;
    logic        start, stop, rise, fall;
    logic        commit;
    logic [7:0]  rd_byte;
    logic [15:0] full_addr;
    logic [7:0]  mem_q [MEM_BYTES];

    seeprom_bus_cond i_cond (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (scl_i),
        .sda_i   (sda_i),
        .start_o (start),
        .stop_o  (stop),
        .rise_o  (rise),
        .fall_o  (fall)
    );

    seeprom_busy_timer #(.CYCLES(BUSY_CYCLES)) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (commit),
        .busy_o  (busy_o)
    );

    assign rd_byte   = mem_q[q.ptr];
    assign full_addr = {q.ahi, q.sh};

    always_comb begin
        d      = q;
        commit = 1'b0;
        if (stop) begin
            d.st   = ST_IDLE;
            d.drv  = 1'b0;
            commit = |q.vld;
            d.vld  = '0;
        end else if (start) begin
            d.st   = ST_RX;
            d.kind = K_DEV;
            d.cnt  = '0;
            d.drv  = 1'b0;
            d.vld  = '0;
        end else begin
            unique case (q.st)
                ST_RX: begin
                    if (rise && q.cnt != 4'd8) begin
                        d.sh  = {q.sh[6:0], sda_i};
                        d.cnt = q.cnt + 4'd1;
                    end else if (fall && q.cnt == 4'd8) begin
                        d.st  = ST_ACK;
                        d.drv = 1'b1;
                        d.cnt = '0;
                        unique case (q.kind)
                            K_DEV: begin
                                if (q.sh[7:1] != DEV_ADDR || busy_o) begin
                                    d.st  = ST_IDLE;
                                    d.drv = 1'b0;
                                end else begin
                                    d.rd = q.sh[0];
                                end
                            end
                            K_AHI: d.ahi = q.sh;
                            K_ALO: d.ptr = full_addr[AW-1:0];
                            K_DATA: begin
                                d.pbuf[q.ptr[OW-1:0]] = q.sh;
                                d.vld[q.ptr[OW-1:0]]  = 1'b1;
                                d.ptr = {q.ptr[AW-1:OW], q.ptr[OW-1:0] + OW'(1)};
                            end
                        endcase
                    end
                end
                ST_ACK: begin
                    if (fall) begin
                        d.drv = 1'b0;
                        d.cnt = '0;
                        if (q.kind == K_DEV && q.rd) begin
                            d.st  = ST_TX;
                            d.sh  = rd_byte;
                            d.drv = ~rd_byte[7];
                            d.ptr = q.ptr + AW'(1);
                        end else begin
                            d.st = ST_RX;
                            unique case (q.kind)
                                K_DEV:  d.kind = K_AHI;
                                K_AHI:  d.kind = K_ALO;
                                default: d.kind = K_DATA;
                            endcase
                        end
                    end
                end
                ST_TX: begin
                    if (rise) begin
                        d.cnt = q.cnt + 4'd1;
                    end else if (fall) begin
                        if (q.cnt == 4'd8) begin
                            d.st  = ST_TXACK;
                            d.drv = 1'b0;
                        end else begin
                            d.sh  = {q.sh[6:0], 1'b0};
                            d.drv = ~q.sh[6];
                        end
                    end
                end
                ST_TXACK: begin
                    if (rise) begin
                        if (sda_i) d.st  = ST_IDLE;
                        else       d.cnt = 4'd9;
                    end else if (fall && q.cnt == 4'd9) begin
                        d.st  = ST_TX;
                        d.cnt = '0;
                        d.sh  = rd_byte;
                        d.drv = ~rd_byte[7];
                        d.ptr = q.ptr + AW'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.kind <= K_DEV;
        end else begin
            q <= d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < MEM_BYTES; i++) mem_q[i] <= '0;
        end else if (commit) begin
            for (int i = 0; i < PAGE_BYTES; i++)
                if (q.vld[i]) mem_q[{q.ptr[AW-1:OW], OW'(i)}] <= q.pbuf[i];
        end
    end

    assign sda_drive_low_o = q.drv;

    // R9: no drive while the FSM waits for the next START
    p_idle_released_r9: assert property (@(posedge clk) disable iff (!rst_n)
        q.st == ST_IDLE |-> !sda_drive_low_o);

    // R6: no header acknowledge while the programming window is open
    p_busy_noack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_ACK && q.kind == K_DEV) |-> !busy_o);

    // R4: the page number is held while data bytes are collected
    p_page_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        q.kind == K_DATA |=> (q.kind != K_DATA) || (q.ptr[AW-1:OW] == $past(q.ptr[AW-1:OW])));

    // R11: the drive changes only after SCL has gone low
    p_sda_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_drive_low_o) |-> !$past(scl_i));

endmodule

// File: tb/test_seeprom_tgt.sv
module test_seeprom_tgt;
    localparam logic [6:0] DEV  = 7'h50;
    localparam int         BUSY = 400;
    localparam int         Q    = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_line;
    logic drive_low;
    logic busy;

    int checks = 0;
    int errors = 0;
    int busy_cnt = 0;
    int r11_viol = 0;
    logic prev_drv = 1'b0;

    int    exp_q[$];
    string tag_q[$];
    int    act_q[$];

    always #5 clk = ~clk;

    assign sda_line = sda_m & ~drive_low;

    seeprom_tgt #(.DEV_ADDR(DEV), .BUSY_CYCLES(BUSY)) i_seeprom_tgt (
        .clk             (clk),
        .rst_n           (rst_n),
        .scl_i           (scl_m),
        .sda_i           (sda_line),
        .sda_drive_low_o (drive_low),
        .busy_o          (busy)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    always @(negedge clk) if (busy) busy_cnt++;

    always @(posedge clk) begin
        #1;
        if (rst_n && drive_low != prev_drv && scl_m) r11_viol++;
        prev_drv = drive_low;
    end

    // scoreboard monitor: compares each received byte with the expected one
    initial begin
        forever begin
            wait (act_q.size() > 0);
            if (exp_q.size() == 0) chk("unexpected byte", act_q.pop_front(), -1);
            else chk(tag_q.pop_front(), act_q.pop_front(), exp_q.pop_front());
        end
    end

    task automatic wq(); repeat (Q) @(negedge clk); endtask

    task automatic put_bit(input logic b);
        wq(); sda_m = b; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0;
    endtask

    task automatic get_bit(output logic b);
        wq(); sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); b = sda_line; wq(); scl_m = 1'b0;
    endtask

    task automatic bus_start();
        wq(); sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        wq(); sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        logic a;
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        get_bit(a);
        acked = ~a;
    endtask

    task automatic recv_byte(input logic ack);
        logic [7:0] b;
        logic x;
        for (int i = 7; i >= 0; i--) begin get_bit(x); b[i] = x; end
        put_bit(~ack);
        act_q.push_back(int'(b));
    endtask

    task automatic expect_byte(input string tag, input logic [7:0] v);
        exp_q.push_back(int'(v));
        tag_q.push_back(tag);
    endtask

    task automatic set_addr(input logic [15:0] a, input string tag);
        logic ak;
        bus_start();
        send_byte({DEV, 1'b0}, ak); chk({tag, " header ack"}, ak, 1);
        send_byte(a[15:8], ak);     chk({tag, " addr hi ack"}, ak, 1);
        send_byte(a[7:0], ak);      chk({tag, " addr lo ack"}, ak, 1);
    endtask

    task automatic read_n(input int n, input string tag);
        logic ak;
        bus_start();
        send_byte({DEV, 1'b1}, ak); chk({tag, " read header ack"}, ak, 1);
        for (int i = 0; i < n; i++) recv_byte(i != n - 1);
        wq();
        chk({tag, " released after NACK (R9)"}, drive_low, 0);
        bus_stop();
        wait (act_q.size() == 0 && exp_q.size() == 0);
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic ak;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 reset state
        chk("R1 drive after reset", drive_low, 0);
        chk("R1 busy after reset", busy, 0);

        // R2 foreign address is not acknowledged
        bus_start();
        send_byte({7'h51, 1'b0}, ak);
        chk("R2 foreign address ack", ak, 0);
        wq();
        chk("R2 released after foreign address", drive_low, 0);
        bus_stop();

        // R3 write three bytes; upper address bits are dropped
        set_addr(16'h7F10, "R3");
        send_byte(8'hA1, ak); chk("R3 data ack", ak, 1);
        send_byte(8'hB2, ak); chk("R3 data ack", ak, 1);
        send_byte(8'hC3, ak); chk("R3 data ack", ak, 1);
        busy_cnt = 0;
        bus_stop();
        chk("R5 busy after data write", busy, 1);

        // R6 own address during busy gets no acknowledge
        bus_start();
        send_byte({DEV, 1'b0}, ak);
        chk("R6 header ack while busy", ak, 0);
        bus_stop();
        chk("R6 still busy", busy, 1);
        wait_idle();
        chk("R5 busy length", busy_cnt, BUSY);

        // R7 random read through repeated START, R3 stored data, R1 zero fill
        set_addr(16'h0010, "R7");
        expect_byte("R7 byte 0x10", 8'hA1);
        expect_byte("R7 byte 0x11", 8'hB2);
        read_n(2, "R7");

        // R10 current-address read continues at 0x12
        expect_byte("R10 byte 0x12", 8'hC3);
        expect_byte("R1 byte 0x13 zero", 8'h00);
        read_n(2, "R10");

        // R4 page wrap: 0x3E, 0x3F, then 0x20, 0x21
        set_addr(16'h003E, "R4");
        send_byte(8'h11, ak); send_byte(8'h22, ak);
        send_byte(8'h33, ak); send_byte(8'h44, ak);
        chk("R4 data ack", ak, 1);
        bus_stop();
        wait_idle();
        set_addr(16'h003E, "R4");
        expect_byte("R4 byte 0x3E", 8'h11);
        expect_byte("R4 byte 0x3F", 8'h22);
        expect_byte("R4 byte 0x40 untouched", 8'h00);
        read_n(3, "R4");
        set_addr(16'h0020, "R4");
        expect_byte("R4 byte 0x20 wrapped", 8'h33);
        expect_byte("R4 byte 0x21 wrapped", 8'h44);
        read_n(2, "R4");

        // R5 address-only write starts no busy period
        set_addr(16'h0005, "R5");
        bus_stop();
        repeat (3) @(negedge clk);
        chk("R5 no busy after address-only write", busy, 0);

        // R8 array wrap on read; R4 write wrap at top page
        set_addr(16'h00FF, "R8");
        send_byte(8'h5A, ak); send_byte(8'h6B, ak);
        chk("R8 data ack", ak, 1);
        bus_stop();
        wait_idle();
        set_addr(16'h00FF, "R8");
        expect_byte("R8 byte 0xFF", 8'h5A);
        expect_byte("R8 wrap to 0x00", 8'h00);
        expect_byte("R8 byte 0x01", 8'h00);
        read_n(3, "R8");
        set_addr(16'h00E0, "R4");
        expect_byte("R4 byte 0xE0 wrapped", 8'h6B);
        read_n(1, "R4");

        // R11 drive only moved while SCL low
        chk("R11 drive changes with SCL high", r11_viol, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule